// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches single 16-bit words from a three-wire serial EEPROM. The EEPROM has one chip select, one serial clock and one data line that both sides share. A client raises `req_valid` with an 8-bit word address while `busy` is low. The reader then runs one complete read transaction and returns the word on `rdata` together with a one-cycle `done` pulse.

Each transaction has the same steps. The reader raises chip select and drives a start bit, the two-bit read command and the address onto the data line. It then stops driving the line, skips the single placeholder bit that the memory sends ahead of its data, and clocks in sixteen data bits. After that it drops chip select. Each word costs a full transaction; the memory's streaming read of the following word is never used.

The data line is brought out as a separate output value, output enable and input, so that the pad or the bench can join them into one wire. A boot sequencer that reads the settings words (addresses 0 to 13) and then the resource table (from word 14 upward) uses this block one word at a time.

Top module: `mw_word_reader`

## Requirements
- R1: While `rst` is high and in the cycle after it, `eep_cs`, `eep_sck`, `eep_sio_oe`, `busy` and `done` are all 0.
- R2: Each transaction presents, on the first 11 rising serial-clock edges, a start bit 1, then command bits 1 then 0, then the 8 address bits most significant first. No other command is ever sent.
- R3: The 16 bits sampled on rising edges 13 to 28 form `rdata`, first bit received in bit 15. `rdata` holds the word from the cycle of `done` until the next transaction's data phase.
- R4: `eep_sio_oe` is 1 at each of the first 11 rising edges and 0 at every later rising edge, so the reader never drives against the memory. It is 0 whenever `eep_cs` is 0.
- R5: Chip select stays high for exactly 28 rising serial-clock edges and then falls; `eep_sck` is low whenever `eep_cs` is low.
- R6: `done` is high for exactly one cycle, in the cycle after the 28th rising edge, and `busy` is high in that cycle.
- R7: A request is accepted only when `busy` is low, and `busy` is high in the next cycle. Requests made while `busy` is high have no effect: no extra transaction runs and `rdata` still returns the word at the accepted address.
- R8: Between two transactions `eep_cs` stays low for at least 2*HALF_DIV system clock cycles.
- R9: Every serial-clock level lasts HALF_DIV system clocks while chip select is high. `eep_sio_out` and `eep_sio_oe` change only while `eep_sck` is low.
- R10: The placeholder bit at rising edge 12 is discarded whatever its value.
- R11: Both ends of the address range (0x00 and 0xFF), and the words on either side of the settings/resource boundary (13 and 14), are read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request, taken when busy is low |
| req_addr | input | 8 | Word address of the request |
| busy | output | 1 | A transaction or the chip-select gap is in progress |
| done | output | 1 | One-cycle pulse: rdata holds the new word |
| rdata | output | 16 | Word read from the EEPROM |
| eep_cs | output | 1 | EEPROM chip select, active high |
| eep_sck | output | 1 | EEPROM serial clock |
| eep_sio_out | output | 1 | Value driven onto the shared data line |
| eep_sio_oe | output | 1 | Drive enable for the shared data line |
| eep_sio_in | input | 1 | Level seen on the shared data line |

## Verification
The hardest case to reach is the handover of the shared line. The reader has to let go of the line at the same falling edge on which the memory starts to drive its placeholder bit. That bit must then drop out of the result whatever level it has. The bench memory model therefore drives the placeholder as 0 in some reads and as 1 in another, and it records drive-enable clashes and enable errors at every rising edge. A request held high throughout a running transaction, and requests issued as soon as `busy` drops, exercise the idle-only acceptance rule and the minimum chip-select gap.

// File: rtl/mw_reader_pkg.sv
package mw_reader_pkg;

    // Header bits that come before the address
    localparam logic       MW_START_BIT = 1'b1;
    localparam logic [1:0] MW_OP_READ   = 2'b10;
    localparam int         MW_PRE_BITS  = 3;

    typedef enum logic [1:0] {
        MW_IDLE,
        MW_XFER,
        MW_TAIL,
        MW_GAP
    } mw_state_e;

endpackage

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mw_hdr_shift.sv
module mw_hdr_shift #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         bit_o
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= load_val;
        end else if (shift) begin
            sreg <= {sreg[W-2:0], 1'b0};
        end
    end

    assign bit_o = sreg[W-1];
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
        end else if (en) begin
            word_o <= {word_o[W-2:0], bit_i};
        end
    end
endmodule

// File: rtl/mw_word_reader.sv
module mw_word_reader
    import mw_reader_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int GAP_HALVES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              eep_cs,
    output logic              eep_sck,
    output logic              eep_sio_out,
    output logic              eep_sio_oe,
    input  logic              eep_sio_in
);
    localparam int HDR_W = MW_PRE_BITS + ADDR_W;
    localparam int TOTAL = HDR_W + 1 + DATA_W;
    localparam int EW    = $clog2(TOTAL + 1);
    localparam int GW    = $clog2(GAP_HALVES + 1);
    localparam logic [EW-1:0] E_LAST_HDR = EW'(HDR_W - 1);
    localparam logic [EW-1:0] E_FIRST_RX = EW'(HDR_W + 1);
    localparam logic [EW-1:0] E_LAST    = EW'(TOTAL - 1);
    localparam logic [GW-1:0] G_LAST    = GW'(GAP_HALVES - 1);

    mw_state_e     state;
    logic [EW-1:0] edge_idx;   // index of the current or next rising edge
    logic [GW-1:0] gap_cnt;
    logic          tick;
    logic          accept;
    logic          hdr_shift;
    logic          rx_en;

    assign accept    = (state == MW_IDLE) && req_valid;
    assign hdr_shift = (state == MW_XFER) && tick && eep_sck;
    assign rx_en     = (state == MW_XFER) && tick && !eep_sck && (edge_idx >= E_FIRST_RX);
    assign busy      = (state != MW_IDLE);

    mw_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    mw_hdr_shift #(.W(HDR_W)) u_hdr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val ({MW_START_BIT, MW_OP_READ, req_addr}),
        .shift    (hdr_shift),
        .bit_o    (eep_sio_out)
    );

    mw_rx_shift #(.W(DATA_W)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .en     (rx_en),
        .bit_i  (eep_sio_in),
        .word_o (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= MW_IDLE;
            eep_cs     <= 1'b0;
            eep_sck    <= 1'b0;
            eep_sio_oe <= 1'b0;
            edge_idx   <= '0;
            gap_cnt    <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                MW_IDLE: begin
                    if (req_valid) begin
                        state      <= MW_XFER;
                        eep_cs     <= 1'b1;
                        eep_sck    <= 1'b0;
                        eep_sio_oe <= 1'b1;
                        edge_idx   <= '0;
                    end
                end
                MW_XFER: begin
                    if (tick) begin
                        if (!eep_sck) begin
                            eep_sck <= 1'b1;           // rising edge: sample
                            if (edge_idx == E_LAST) begin
                                done  <= 1'b1;
                                state <= MW_TAIL;
                            end
                        end else begin
                            eep_sck  <= 1'b0;          // falling edge: advance
                            edge_idx <= edge_idx + 1'b1;
                            if (edge_idx == E_LAST_HDR) begin
                                eep_sio_oe <= 1'b0;    // hand the line over
                            end
                        end
                    end
                end
                MW_TAIL: begin
                    if (tick) begin
                        eep_sck <= 1'b0;
                        eep_cs  <= 1'b0;
                        gap_cnt <= '0;
                        state   <= MW_GAP;
                    end
                end
                MW_GAP: begin
                    if (tick) begin
                        if (gap_cnt == G_LAST) begin
                            state <= MW_IDLE;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                end
                default: state <= MW_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mw_reader_chk.sv
module mw_reader_chk #(
    parameter int TOTAL = 28
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic eep_cs,
    input logic eep_sck,
    input logic eep_sio_out,
    input logic eep_sio_oe
);
    localparam int CW = $clog2(TOTAL + 2);

    logic          sck_q;
    logic [CW-1:0] rises;
    logic          rise_now;

    assign rise_now = eep_sck && !sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            rises <= '0;
        end else begin
            sck_q <= eep_sck;
            if (!eep_cs) begin
                rises <= '0;
            end else if (rise_now) begin
                rises <= rises + 1'b1;
            end
        end
    end

    a_r4_release_when_deselected: assert property (@(posedge clk) disable iff (rst)
        !eep_cs |-> !eep_sio_oe);

    a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        !eep_cs |-> !eep_sck);

    a_r5_edge_count: assert property (@(posedge clk) disable iff (rst)
        $fell(eep_cs) |-> (rises == CW'(TOTAL)));

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_done_while_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r6_done_after_last_edge: assert property (@(posedge clk) disable iff (rst)
        done |-> ((rises + CW'(rise_now)) == CW'(TOTAL)));

    a_r7_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    a_r9_line_stable_high: assert property (@(posedge clk) disable iff (rst)
        (eep_cs && eep_sck && $past(eep_sck)) |-> ($stable(eep_sio_out) && $stable(eep_sio_oe)));
endmodule

bind mw_word_reader mw_reader_chk #(.TOTAL(TOTAL)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .busy        (busy),
    .done        (done),
    .eep_cs      (eep_cs),
    .eep_sck     (eep_sck),
    .eep_sio_out (eep_sio_out),
    .eep_sio_oe  (eep_sio_oe)
);

// File: tb/tb_mw_word_reader.sv
`timescale 1ns/1ps
module tb_mw_word_reader;
    localparam int HALF_DIV = 2;
    localparam int NRISE    = 28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_addr = '0;
    logic        busy, done, eep_cs, eep_sck, eep_sio_out, eep_sio_oe;
    logic [15:0] rdata;
    logic        sio_line;

    // memory model state
    logic        m_oe = 1'b0;
    logic        m_out = 1'b0;
    logic        dummy_val = 1'b0;
    logic        prev_sck = 1'b0;
    logic        prev_cs = 1'b0;
    logic [10:0] hdr = '0;
    int          bitn = 0, rises = 0, cyc = 0, last_chg = 0, fall_cyc = 0;
    int          ntrans = 0, last_rises = 0, min_gap = 1000000;
    int          oe_err = 0, clash = 0, per_err = 0;
    logic        last_start = 1'b0;
    logic [1:0]  last_opc = '0;
    logic [7:0]  last_addr = '0;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    assign sio_line = eep_sio_oe ? eep_sio_out : (m_oe ? m_out : 1'b1);

    mw_word_reader #(.HALF_DIV(HALF_DIV)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .done(done), .rdata(rdata), .eep_cs(eep_cs), .eep_sck(eep_sck),
        .eep_sio_out(eep_sio_out), .eep_sio_oe(eep_sio_oe), .eep_sio_in(sio_line)
    );

    function automatic logic [15:0] mem_word(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

    // behavioural EEPROM, evaluated between active edges
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (eep_cs && !prev_cs) begin
            if (ntrans > 0 && (cyc - fall_cyc) < min_gap) min_gap = cyc - fall_cyc;
            bitn = 0; rises = 0; hdr = '0; m_oe = 1'b0; last_chg = cyc;
        end
        if (eep_cs) begin
            if (eep_sck != prev_sck) begin
                if (cyc - last_chg != HALF_DIV) per_err = per_err + 1;
                last_chg = cyc;
            end
            if (eep_sck && !prev_sck) begin
                rises = rises + 1;
                if (eep_sio_oe && m_oe) clash = clash + 1;
                if (bitn < 11) begin
                    hdr = {hdr[9:0], sio_line};
                    if (!eep_sio_oe) oe_err = oe_err + 1;
                end else if (eep_sio_oe) begin
                    oe_err = oe_err + 1;
                end
                bitn = bitn + 1;
            end
            if (!eep_sck && prev_sck) begin
                if (bitn == 11) begin
                    m_oe = 1'b1; m_out = dummy_val;
                end else if (bitn >= 12 && bitn <= 27) begin
                    m_out = mem_word(hdr[7:0])[27 - bitn];
                end
            end
        end
        if (!eep_cs && prev_cs) begin
            ntrans = ntrans + 1;
            last_start = hdr[10]; last_opc = hdr[9:8]; last_addr = hdr[7:0];
            last_rises = rises; m_oe = 1'b0; fall_cyc = cyc;
        end
        prev_sck = eep_sck;
        prev_cs  = eep_cs;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic do_read(input logic [7:0] a, input logic dv, input string tag);
        logic seen;
        int   n0;
        n0 = ntrans;
        dummy_val = dv;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy, "R7 busy after accept", busy, 1);
        wait_done(seen);
        check(seen, {tag, " done seen"}, seen, 1);
        check(rdata == mem_word(a), {tag, " rdata"}, rdata, mem_word(a));   // R3, R11
        check(busy, "R6 busy with done", busy, 1);
        @(negedge clk);
        check(!done, "R6 done one cycle", done, 0);
        wait_idle();
        check(ntrans == n0 + 1, "R5 one transaction", ntrans - n0, 1);
        check(last_start == 1'b1 && last_opc == 2'b10, "R2 start+read command",
              {last_start, last_opc}, 3'b110);
        check(last_addr == a, "R2 address", last_addr, a);
        check(last_rises == NRISE, "R5 rising edges", last_rises, NRISE);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!eep_cs && !eep_sck && !eep_sio_oe && !busy && !done, "R1 reset state",
              {eep_cs, eep_sck, eep_sio_oe, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!eep_cs && !busy && !done, "R1 after reset", {eep_cs, busy, done}, 0);
    endtask

    task automatic t_ignore_busy();
        logic seen;
        int   n0;
        n0 = ntrans;
        dummy_val = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 8'h3C;
        @(negedge clk);
        req_addr = 8'hC3;                 // R7: held request with other address
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen);
        check(seen && rdata == mem_word(8'h3C), "R7 busy request ignored", rdata, mem_word(8'h3C));
        wait_idle();
        check(ntrans == n0 + 1 && last_addr == 8'h3C, "R7 single transaction", last_addr, 8'h3C);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        do_read(8'h00, 1'b0, "R11 addr 0x00");
        do_read(8'hFF, 1'b0, "R11 addr 0xFF");
        do_read(8'd13, 1'b0, "R11 last settings word");
        do_read(8'd14, 1'b0, "R11 first resource word");
        do_read(8'hA5, 1'b1, "R10 dummy bit high");
        do_read(8'h81, 1'b1, "R10 dummy bit high 2");
        t_ignore_busy();
        do_read(8'h7E, 1'b0, "R3 back-to-back");
        check(oe_err == 0, "R4 drive enable at rising edges", oe_err, 0);
        check(clash == 0, "R4 no line contention", clash, 0);
        check(per_err == 0, "R9 serial clock half period", per_err, 0);
        check(min_gap >= 2 * HALF_DIV, "R8 chip-select gap", min_gap, 2 * HALF_DIV);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule